// File: doc/BRIEF.md
# Eight-Bit Timer/Counter with Compare Match and Fast PWM

This block is an 8-bit up-counter peripheral for a small microcontroller. Software programs it through a simple write port and a registered read port. The counter advances only on cycles where an external tick input is high; that input plays the role of the prescaler output. A clock-select field of zero halts counting.

Three counting modes are offered:
- **Free-running.** The count runs to 0xFF and wraps to zero.
- **Clear-on-compare.** The count runs up to compare register A, holds that value for one step, and then returns to zero.
- **Fast PWM.** Counting is free-running, and the two compare registers are double-buffered.

The block keeps three sticky status flags: overflow, compare-A match and compare-B match. Software clears a flag by writing a one to its bit. Each flag is gated by a mask bit to form an interrupt request output.

The overflow flag depends on where the turnaround point lies. In clear-on-compare mode with compare A below 0xFF, the overflow flag is never raised. With compare A at 0xFF, the step that reaches 0xFF raises both the overflow flag and the compare-A flag.

Top module: `tc8_timer`

## Requirements
- R1: After reset, the following are all zero: the count, both compare values, the control, mask and flag registers, `rd_data`, and every flag and interrupt output.
- R2: The count increases by one only on a cycle where `tick` is high and the clock-select field (control bits [4:2]) is nonzero. On any other cycle the count is unchanged.
- R3: The mode field is control bits [1:0]: 0 selects free-running, 1 selects clear-on-compare, 2 selects fast PWM, and 3 behaves as free-running. In free-running and fast PWM modes, a step taken from 0xFF gives 0x00 and sets the overflow flag.
- R4: In clear-on-compare mode, a step taken while the count equals compare A gives zero. A count above compare A keeps counting up until it wraps from 0xFF to zero.
- R5: In clear-on-compare mode with compare A below 0xFF, the overflow flag is never set.
- R6: In clear-on-compare mode with compare A equal to 0xFF, a step from 0xFE to 0xFF sets both the overflow flag and the compare-A flag.
- R7: The compare-A flag is set by a step whose new count equals the active compare A, provided compare A is nonzero. The compare-B flag follows the same rule with compare B. A compare value of zero never sets its flag.
- R8: In fast PWM mode, a compare write updates only a pending copy. The active value takes the pending copy on the step from 0xFF to 0x00. In the other modes a compare write takes effect at once. Reads of the compare addresses return the active value.
- R9: A count write takes priority over that cycle's count step: the count takes the written value, and that cycle raises no flag and copies no pending compare. A count write by itself never sets a flag.
- R10: The flag register holds overflow at bit 0, compare-A at bit 1 and compare-B at bit 2. Writing a one to a bit clears that flag, and writing a zero leaves it unchanged. If hardware sets a flag in the same cycle that software clears it, the flag ends up set.
- R11: Each interrupt output is high exactly when its flag is set and the matching bit of the mask register (same bit layout as the flags) is one.
- R12: The register addresses are: 0 control, 1 count, 2 compare A, 3 compare B, 4 mask, 5 flags. `rd_data` returns the register at `rd_addr` one cycle later. Addresses 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable from the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Registered read data |
| ovf_flag | output | 1 | Overflow flag |
| cmpa_flag | output | 1 | Compare-A match flag |
| cmpb_flag | output | 1 | Compare-B match flag |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_cmpa | output | 1 | Compare-A interrupt request |
| irq_cmpb | output | 1 | Compare-B interrupt request |

## Verification
Counting is tried in several ways: with sparse tick pulses, with a zero clock select, and with free-running steps across 0xFF. Together these separate tick gating from the clock-select gate and show where the wrap flag comes from.

Clear-on-compare is run twice, with compare A at 0x1F and at 0xFF. This tells the suppressed overflow apart from the raised one. A start above compare A shows that the count climbs on to 0xFF and wraps.

Fast PWM compare writes are read back before and after the wrap step, which shows the pending/active split. Count and flag writes are issued in the same cycle as a step, which exposes the write-over-step priority and the set-over-clear priority.

// File: rtl/tc8_pkg.sv
package tc8_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_CTC    = 2'd1,
    MODE_FPWM   = 2'd2,
    MODE_ALT    = 2'd3
  } tc_mode_e;

  localparam int A_CTRL  = 0;
  localparam int A_COUNT = 1;
  localparam int A_CMPA  = 2;
  localparam int A_CMPB  = 3;
  localparam int A_MASK  = 4;
  localparam int A_FLAGS = 5;

  localparam int F_OVF   = 0;
  localparam int F_CMPA  = 1;
  localparam int F_CMPB  = 2;
  localparam int NFLAGS  = 3;
  localparam int NCMP    = 2;
endpackage

// File: rtl/tc8_cmp_reg.sv
module tc8_cmp_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         buffered,
  input  logic         load,
  output logic [W-1:0] active
);
  logic [W-1:0] pending;

  // A copy at the wrap takes the pending value held before this cycle's write.
  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= '0;
      pending <= '0;
    end else begin
      if (load) active <= pending;
      if (wr) begin
        pending <= wdata;
        if (!buffered) active <= wdata;
      end
    end
  end
endmodule

// File: rtl/tc8_counter.sv
module tc8_counter
  import tc8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         load_cnt,
  input  logic [W-1:0] load_val,
  input  tc_mode_e     mode,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  output logic [W-1:0] count,
  output logic         ev_wrap,
  output logic         ev_ovf,
  output logic         ev_cmpa,
  output logic         ev_cmpb
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic         adv;
  logic         at_top;
  logic [W-1:0] top_val;
  logic [W-1:0] nxt;

  always_comb begin
    adv     = step && !load_cnt;
    top_val = (mode == MODE_CTC) ? cmp_a : MAXV;
    at_top  = (count == top_val) || (count == MAXV);
    nxt     = at_top ? '0 : count + 1'b1;
    ev_wrap = adv && at_top;
    if (mode == MODE_CTC) ev_ovf = adv && (cmp_a == MAXV) && (nxt == MAXV);
    else                  ev_ovf = adv && at_top;
    ev_cmpa = adv && (cmp_a != '0) && (nxt == cmp_a);
    ev_cmpb = adv && (cmp_b != '0) && (nxt == cmp_b);
  end

  always_ff @(posedge clk) begin
    if (rst)           count <= '0;
    else if (load_cnt) count <= load_val;
    else if (adv)      count <= nxt;
  end
endmodule

// File: rtl/tc8_flags.sv
module tc8_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic         clr_we,
  input  logic [N-1:0] clr_bits,
  output logic [N-1:0] flags
);
  logic [N-1:0] clr;

  assign clr = clr_we ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~clr) | set;
  end
endmodule

// File: rtl/tc8_timer.sv
module tc8_timer
  import tc8_pkg::*;
#(
  parameter int W   = 8,
  parameter int AW  = 3,
  parameter int CSW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  output logic          ovf_flag,
  output logic          cmpa_flag,
  output logic          cmpb_flag,
  output logic          irq_ovf,
  output logic          irq_cmpa,
  output logic          irq_cmpb
);
  localparam int CS_LO = 2;
  localparam int CS_HI = CS_LO + CSW - 1;

  logic [1:0]        mode_q;
  tc_mode_e          mode;
  logic [CSW-1:0]    csel_q;
  logic [NFLAGS-1:0] mask_q;
  logic [NFLAGS-1:0] flags;
  logic [W-1:0]      count;
  logic [W-1:0]      cmp_act [NCMP];
  logic              ev_wrap, ev_ovf, ev_cmpa, ev_cmpb;
  logic              wr_ctrl, wr_cnt, wr_mask, wr_flags;
  logic              pwm;
  logic [W-1:0]      rd_mux;

  assign mode     = tc_mode_e'(mode_q);
  assign pwm      = (mode == MODE_FPWM);
  assign wr_ctrl  = wr_en && (wr_addr == AW'(A_CTRL));
  assign wr_cnt   = wr_en && (wr_addr == AW'(A_COUNT));
  assign wr_mask  = wr_en && (wr_addr == AW'(A_MASK));
  assign wr_flags = wr_en && (wr_addr == AW'(A_FLAGS));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      csel_q <= '0;
      mask_q <= '0;
    end else begin
      if (wr_ctrl) begin
        mode_q <= wr_data[1:0];
        csel_q <= wr_data[CS_HI:CS_LO];
      end
      if (wr_mask) mask_q <= wr_data[NFLAGS-1:0];
    end
  end

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    tc8_cmp_reg #(.W(W)) u_cmp (
      .clk      (clk),
      .rst      (rst),
      .wr       (wr_en && (wr_addr == AW'(A_CMPA + g))),
      .wdata    (wr_data),
      .buffered (pwm),
      .load     (ev_wrap && pwm),
      .active   (cmp_act[g])
    );
  end

  tc8_counter #(.W(W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .step     (tick && (csel_q != '0)),
    .load_cnt (wr_cnt),
    .load_val (wr_data),
    .mode     (mode),
    .cmp_a    (cmp_act[0]),
    .cmp_b    (cmp_act[1]),
    .count    (count),
    .ev_wrap  (ev_wrap),
    .ev_ovf   (ev_ovf),
    .ev_cmpa  (ev_cmpa),
    .ev_cmpb  (ev_cmpb)
  );

  tc8_flags #(.N(NFLAGS)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .set      ({ev_cmpb, ev_cmpa, ev_ovf}),
    .clr_we   (wr_flags),
    .clr_bits (wr_data[NFLAGS-1:0]),
    .flags    (flags)
  );

  always_comb begin
    rd_mux = '0;
    case (rd_addr)
      AW'(A_CTRL): begin
        rd_mux[1:0]         = mode_q;
        rd_mux[CS_HI:CS_LO] = csel_q;
      end
      AW'(A_COUNT): rd_mux = count;
      AW'(A_CMPA):  rd_mux = cmp_act[0];
      AW'(A_CMPB):  rd_mux = cmp_act[1];
      AW'(A_MASK):  rd_mux[NFLAGS-1:0] = mask_q;
      AW'(A_FLAGS): rd_mux[NFLAGS-1:0] = flags;
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end

  assign ovf_flag  = flags[F_OVF];
  assign cmpa_flag = flags[F_CMPA];
  assign cmpb_flag = flags[F_CMPB];
  assign irq_ovf   = flags[F_OVF]  & mask_q[F_OVF];
  assign irq_cmpa  = flags[F_CMPA] & mask_q[F_CMPA];
  assign irq_cmpb  = flags[F_CMPB] & mask_q[F_CMPB];
endmodule

// File: rtl/tc8_timer_chk.sv
module tc8_timer_chk
  import tc8_pkg::*;
#(
  parameter int W   = 8,
  parameter int AW  = 3,
  parameter int CSW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [W-1:0]  wr_data,
  input logic [1:0]    mode,
  input logic [CSW-1:0] csel,
  input logic [NFLAGS-1:0] mask,
  input logic [W-1:0]  count,
  input logic [W-1:0]  cmpa,
  input logic          ev_ovf,
  input logic          ovf_flag,
  input logic          irq_ovf
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic cnt_wr, run, flg_wr;
  assign cnt_wr = wr_en && (wr_addr == AW'(A_COUNT));
  assign flg_wr = wr_en && (wr_addr == AW'(A_FLAGS));
  assign run    = tick && (csel != '0);

  // R2
  count_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_wr) |=> $stable(count));

  // R3
  normal_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'(MODE_NORMAL) && run && !cnt_wr && count == MAXV) |=> (count == '0 && ovf_flag));

  // R4
  ctc_return_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'(MODE_CTC) && run && !cnt_wr && count == cmpa) |=> (count == '0));

  // R5
  ctc_no_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'(MODE_CTC) && cmpa != MAXV) |=> !$rose(ovf_flag));

  // R8
  pwm_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'(MODE_FPWM) && !(run && !cnt_wr && count == MAXV)) |=> $stable(cmpa));

  // R9
  cnt_write_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (count == $past(wr_data)));

  // R10
  flag_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ev_ovf |=> ovf_flag);

  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (flg_wr && wr_data[F_OVF] && !ev_ovf) |=> !ovf_flag);

  // R11
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    !mask[F_OVF] |-> !irq_ovf);
endmodule

bind tc8_timer tc8_timer_chk #(.W(W), .AW(AW), .CSW(CSW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .mode     (mode_q),
  .csel     (csel_q),
  .mask     (mask_q),
  .count    (count),
  .cmpa     (cmp_act[0]),
  .ev_ovf   (ev_ovf),
  .ovf_flag (ovf_flag),
  .irq_ovf  (irq_ovf)
);

// File: tb/tc8_timer_tb.sv
`timescale 1ns/1ps
module tc8_timer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       ovf_flag, cmpa_flag, cmpb_flag, irq_ovf, irq_cmpa, irq_cmpb;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tc8_timer u_dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ovf_flag(ovf_flag), .cmpa_flag(cmpa_flag), .cmpb_flag(cmpb_flag),
    .irq_ovf(irq_ovf), .irq_cmpa(irq_cmpa), .irq_cmpb(irq_cmpb)
  );

  // Behavioural reference model
  int m_count, m_ca, m_cb, m_pa, m_pb, m_mode, m_csel, m_mask, m_flags, m_rd;
  int t_top, t_nx, t_set, t_clr;
  bit t_wc, t_adv, t_wrap, t_pwm;

  function automatic int model_read(int a);
    case (a)
      0: return (m_csel << 2) | m_mode;
      1: return m_count;
      2: return m_ca;
      3: return m_cb;
      4: return m_mask;
      5: return m_flags;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_count = 0; m_ca = 0; m_cb = 0; m_pa = 0; m_pb = 0;
      m_mode = 0; m_csel = 0; m_mask = 0; m_flags = 0; m_rd = 0;
    end else begin
      m_rd   = model_read(int'(rd_addr));
      t_wc   = wr_en && wr_addr == 3'd1;
      t_adv  = tick && m_csel != 0 && !t_wc;
      t_top  = (m_mode == 1) ? m_ca : 255;
      t_wrap = (m_count == t_top) || (m_count == 255);
      t_nx   = t_wrap ? 0 : m_count + 1;
      t_set  = 0;
      if (t_adv) begin
        if (m_mode == 1) begin
          if (m_ca == 255 && t_nx == 255) t_set |= 1;
        end else if (t_wrap) t_set |= 1;
        if (m_ca != 0 && t_nx == m_ca) t_set |= 2;
        if (m_cb != 0 && t_nx == m_cb) t_set |= 4;
      end
      t_pwm   = (m_mode == 2);
      t_clr   = (wr_en && wr_addr == 3'd5) ? int'(wr_data[2:0]) : 0;
      m_flags = (m_flags & ~t_clr & 7) | t_set;
      if (t_pwm && t_adv && t_wrap) begin
        m_ca = m_pa;
        m_cb = m_pb;
      end
      if (t_adv) m_count = t_nx;
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin m_mode = int'(wr_data[1:0]); m_csel = int'(wr_data[4:2]); end
          3'd1: m_count = int'(wr_data);
          3'd2: begin m_pa = int'(wr_data); if (!t_pwm) m_ca = int'(wr_data); end
          3'd3: begin m_pb = int'(wr_data); if (!t_pwm) m_cb = int'(wr_data); end
          3'd4: m_mask = int'(wr_data[2:0]);
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string tag, int got, int exp);
    nchk++;
    if (got != exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R10 flags vs model", int'({cmpb_flag, cmpa_flag, ovf_flag}), m_flags);
      chk("R11 irqs vs model", int'({irq_cmpb, irq_cmpa, irq_ovf}), m_flags & m_mask);
      chk("R12 rd_data vs model", int'(rd_data), m_rd);
    end
  end

  task automatic cyc(int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    rd_addr = 3'(a);
    cyc(1);
    v = int'(rd_data);
  endtask

  task automatic step(int n);
    tick = 1'b1;
    cyc(n);
    tick = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      nerr++; nchk++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int v;
    cyc(3);
    rst = 1'b0;
    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(a, v);
      chk("R1 reset register", v, 0);
    end
    chk("R1 reset flags", int'({cmpb_flag, cmpa_flag, ovf_flag}), 0);
    chk("R1 reset irqs", int'({irq_cmpb, irq_cmpa, irq_ovf}), 0);

    // R2 tick and clock-select gating
    wr(0, 8'h04);
    cyc(5);
    rd(1, v); chk("R2 no tick holds count", v, 0);
    repeat (3) begin tick = 1'b1; cyc(1); tick = 1'b0; cyc(1); end
    rd(1, v); chk("R2 three ticks", v, 3);
    wr(0, 8'h00);
    step(4);
    rd(1, v); chk("R2 clock select zero stops", v, 3);

    // R3 free-running wrap
    wr(0, 8'h04);
    wr(1, 8'hFD);
    step(2);
    chk("R3 no overflow before wrap", int'(ovf_flag), 0);
    step(1);
    chk("R3 overflow at wrap", int'(ovf_flag), 1);
    rd(1, v); chk("R3 count wraps to zero", v, 0);
    chk("R7 zero compare never matches", int'(cmpa_flag), 0);

    // R10 write-one-to-clear and set wins
    wr(5, 1);
    chk("R10 clear overflow", int'(ovf_flag), 0);
    wr(1, 8'hFF);
    tick = 1'b1;
    wr(5, 1);
    tick = 1'b0;
    chk("R10 set beats clear", int'(ovf_flag), 1);
    wr(5, 0);
    chk("R10 write zero keeps flag", int'(ovf_flag), 1);
    wr(5, 7);
    chk("R10 clear all", int'(ovf_flag), 0);

    // R11 interrupt masking
    wr(4, 1);
    wr(1, 8'hFF);
    step(1);
    chk("R11 irq with mask", int'(irq_ovf), 1);
    wr(4, 0);
    chk("R11 irq masked off", int'(irq_ovf), 0);
    wr(5, 7);

    // R4 / R5 clear-on-compare with compare below max
    wr(0, 8'h05);
    wr(2, 8'h1F);
    wr(1, 8'h1E);
    step(1);
    rd(1, v); chk("R4 reaches compare", v, 8'h1F);
    chk("R5 compare flag set", int'(cmpa_flag), 1);
    chk("R5 no overflow at top", int'(ovf_flag), 0);
    step(1);
    rd(1, v); chk("R4 returns to zero", v, 0);
    step(100);
    chk("R5 no overflow over many periods", int'(ovf_flag), 0);
    wr(1, 8'h30);
    step(1);
    rd(1, v); chk("R4 above compare counts up", v, 8'h31);
    wr(1, 8'hFF);
    step(1);
    rd(1, v); chk("R4 above compare wraps", v, 0);
    chk("R5 no overflow at max wrap", int'(ovf_flag), 0);

    // R6 clear-on-compare with compare at max
    wr(5, 7);
    wr(2, 8'hFF);
    wr(1, 8'hFE);
    step(1);
    rd(1, v); chk("R6 count at max", v, 8'hFF);
    chk("R6 overflow set", int'(ovf_flag), 1);
    chk("R6 compare A set", int'(cmpa_flag), 1);
    step(1);
    rd(1, v); chk("R6 then zero", v, 0);

    // R7 compare B
    wr(0, 8'h04);
    wr(5, 7);
    wr(3, 8'h10);
    wr(1, 8'h0F);
    step(1);
    chk("R7 compare B set", int'(cmpb_flag), 1);
    chk("R7 compare A not set", int'(cmpa_flag), 0);

    // R8 immediate and buffered compare writes
    wr(2, 8'h20);
    rd(2, v); chk("R8 immediate in normal", v, 8'h20);
    wr(0, 8'h06);
    wr(2, 8'h40);
    rd(2, v); chk("R8 buffered write held", v, 8'h20);
    wr(1, 8'hFE);
    step(1);
    rd(2, v); chk("R8 held before wrap", v, 8'h20);
    step(1);
    rd(2, v); chk("R8 loaded at wrap", v, 8'h40);

    // R9 count write priority
    wr(5, 7);
    wr(1, 8'hFF);
    tick = 1'b1;
    wr(1, 8'h05);
    tick = 1'b0;
    rd(1, v); chk("R9 write beats step", v, 8'h05);
    chk("R9 no overflow from overridden step", int'(ovf_flag), 0);
    wr(1, 8'h40);
    chk("R9 count write sets no compare flag", int'(cmpa_flag), 0);

    // R12 register map
    rd(6, v); chk("R12 address 6 reads zero", v, 0);
    rd(7, v); chk("R12 address 7 reads zero", v, 0);
    rd(0, v); chk("R12 control readback", v, 8'h06);
    wr(4, 5);
    rd(4, v); chk("R12 mask readback", v, 5);

    cyc(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule